// File: doc/BRIEF.md
# Oldest-First Multi-Class Issue Selector

This block sits between the ready lists of an out-of-order core and its execution units. Each operation class offers at most one candidate per cycle: the oldest ready instruction of that class, with its sequence number and a squash flag. In the same cycle the selector ranks the classes by the age of their candidates. It then walks them from oldest to youngest and grants up to an issue-width number of instructions. It stops early when the downstream stage withholds `can_issue`.

Class 0 stands for operations that need no functional unit. Every other class owns one unit, described by a latency and a pipelined flag in a table input. A granted operation of latency 1 appears on the execute outputs in the same cycle. An operation of longer latency raises a completion pulse a fixed number of cycles later. A non-pipelined unit stays occupied until that pulse. A class whose unit is occupied is passed over, which lets a younger class issue in its place, and its busy counter is bumped.

Each candidate port follows a valid/ready rule. `req_valid` must stay high with stable `req_seq` and `req_squash` until `req_ready` is seen high at a clock edge. After such an edge the source presents its next oldest instruction, or drops valid. `req_ready` is combinational from the current inputs and the unit state. The execute and completion outputs carry no back-pressure; the only throttle is `can_issue`.

Top module: `iss_oldest_select`

## Requirements
- R1: After reset, no completion is pending, no unit is held, every busy counter reads 0, and with no valid candidate `req_ready`, `exe_valid`, `cmpl_valid` and `issue_count` are all 0.
- R2: At most ISSUE_W non-squashed candidates are granted in a cycle, and `issue_count` equals the number granted in that cycle.
- R3: While `can_issue` is low no candidate is granted or discarded (`req_ready` is all zero).
- R4: Classes are examined in increasing order of their candidate's sequence number. When more candidates are eligible than ISSUE_W, the ISSUE_W oldest are the ones granted.
- R5: A squashed candidate reached in the walk is taken (`req_ready` high) but is not executed and does not use an issue slot. A squashed candidate behind a full set of grants is left in place.
- R6: Class 0 needs no unit and always issues with latency 1, whatever its table entry says.
- R7: A granted operation whose effective latency is 1 raises `exe_valid[c]` with `exe_seq` equal to its sequence number in the same cycle. A table latency of 0 counts as 1.
- R8: A granted operation of latency L>1 (field `unit_lat[c*LAT_W +: LAT_W]`) raises no execute output. It raises `cmpl_valid[c]` with its sequence number exactly L-1 cycles after the grant cycle.
- R9: A non-pipelined unit (`unit_pipe[c]`=0) with L>1 is held from its grant until its completion cycle inclusive, and may be granted again in the cycle after the completion pulse.
- R10: A pipelined unit with L>1 accepts a new operation every cycle, and each gets its own completion pulse.
- R11: A non-squashed candidate reached in the walk whose unit is held is skipped: its `busy_cnt` field (`busy_cnt[c*CNT_W +: CNT_W]`) rises by one at the next edge, and the walk continues with younger classes.
- R12: `req_ready[c]` is only high where `req_valid[c]` is high, and each class gives up at most one candidate per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| can_issue | input | 1 | Downstream can take instructions this cycle |
| req_valid | input | NC | Candidate present, one bit per class |
| req_seq | input | NC*SEQ_W | Candidate sequence numbers, class c at bits c*SEQ_W |
| req_squash | input | NC | Candidate has been squashed |
| req_ready | output | NC | Candidate taken (granted or discarded) this cycle |
| unit_lat | input | NC*LAT_W | Unit latency per class, class c at bits c*LAT_W |
| unit_pipe | input | NC | Unit is pipelined per class |
| exe_valid | output | NC | Latency-1 operation sent to execute |
| exe_seq | output | NC*SEQ_W | Sequence number of the executed operation |
| cmpl_valid | output | NC | Multi-cycle operation completes this cycle |
| cmpl_seq | output | NC*SEQ_W | Sequence number of the completing operation |
| issue_count | output | $clog2(NC+1) | Number of grants this cycle |
| busy_cnt | output | NC*CNT_W | Per-class count of skips for a held unit |

## Verification
The hardest situation to reach is a held non-pipelined unit meeting a younger candidate of another class in the same cycle. The skip, the busy count and the younger grant must all happen together, and the unit must then be released exactly one cycle after its completion pulse. The stimulus first grants a latency-3 non-pipelined operation. It then keeps re-offering that class next to younger candidates through the hold window and the completion cycle, and the scoreboard checks each execute and completion event against its expected cycle. A second pattern mixes a squashed oldest candidate with a full issue width. This shows that the discard costs no slot and that a class behind the full width is not reached.

// File: rtl/iss_sel_pkg.sv
package iss_sel_pkg;
  localparam int DEF_CLASSES = 4;
  localparam int DEF_SEQ_W   = 16;
  localparam int DEF_ISSUE_W = 2;
  localparam int DEF_LAT_W   = 3;
  localparam int DEF_CNT_W   = 16;
endpackage

// File: rtl/iss_age_matrix.sv
module iss_age_matrix #(
  parameter int NC    = 4,
  parameter int SEQ_W = 16
) (
  input  logic [NC-1:0]       vld,
  input  logic [NC*SEQ_W-1:0] seq,
  output logic [NC*NC-1:0]    older
);
  // older[c*NC+j] is set when class j holds a valid candidate older than class c's
  for (genvar c = 0; c < NC; c++) begin : g_row
    for (genvar j = 0; j < NC; j++) begin : g_col
      if (c == j) begin : g_self
        assign older[c*NC+j] = 1'b0;
      end else begin : g_pair
        assign older[c*NC+j] = vld[j] && vld[c] &&
                               (seq[j*SEQ_W +: SEQ_W] < seq[c*SEQ_W +: SEQ_W]);
      end
    end
  end
endmodule

// File: rtl/iss_unit_track.sv
module iss_unit_track #(
  parameter int SEQ_W   = 16,
  parameter int LAT_W   = 3,
  parameter bit NO_UNIT = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             grant,
  input  logic [LAT_W-1:0] lat_eff,
  input  logic             pipe,
  input  logic [SEQ_W-1:0] seq,
  output logic             free,
  output logic             cmpl_v,
  output logic [SEQ_W-1:0] cmpl_seq
);
  localparam int DEPTH = (1 << LAT_W) - 2;

  logic             slot_v  [DEPTH];
  logic [SEQ_W-1:0] slot_s  [DEPTH];
  logic             nslot_v [DEPTH];
  logic [SEQ_W-1:0] nslot_s [DEPTH];
  logic             long_op;

  assign long_op = grant && (lat_eff > LAT_W'(1));

  // Delay line: an operation of latency L enters slot L-2 and leaves from slot 0
  always_comb begin
    for (int d = 0; d < DEPTH; d++) begin
      if (d < DEPTH - 1) begin
        nslot_v[d] = slot_v[d+1];
        nslot_s[d] = slot_s[d+1];
      end else begin
        nslot_v[d] = 1'b0;
        nslot_s[d] = '0;
      end
      if (long_op && (int'(lat_eff) == d + 2)) begin
        nslot_v[d] = 1'b1;
        nslot_s[d] = seq;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int d = 0; d < DEPTH; d++) begin
      if (!rst_n) begin
        slot_v[d] <= 1'b0;
        slot_s[d] <= '0;
      end else begin
        slot_v[d] <= nslot_v[d];
        slot_s[d] <= nslot_s[d];
      end
    end
  end

  assign cmpl_v   = slot_v[0];
  assign cmpl_seq = slot_s[0];

  if (NO_UNIT) begin : g_nounit
    assign free = 1'b1;
  end else begin : g_unit
    logic held;
    always_ff @(posedge clk) begin
      if (!rst_n)               held <= 1'b0;
      else if (long_op && !pipe) held <= 1'b1;
      else if (slot_v[0])        held <= 1'b0;
    end
    assign free = !held;
  end
endmodule

// File: rtl/iss_busy_ctr.sv
module iss_busy_ctr #(
  parameter int NC    = 4,
  parameter int CNT_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NC-1:0]       hit,
  output logic [NC*CNT_W-1:0] cnt
);
  for (genvar c = 0; c < NC; c++) begin : g_ctr
    logic [CNT_W-1:0] val;
    always_ff @(posedge clk) begin
      if (!rst_n)      val <= '0;
      else if (hit[c]) val <= val + CNT_W'(1);
    end
    assign cnt[c*CNT_W +: CNT_W] = val;
  end
endmodule

// File: rtl/iss_oldest_select.sv
module iss_oldest_select
  import iss_sel_pkg::*;
#(
  parameter int NC      = DEF_CLASSES,
  parameter int SEQ_W   = DEF_SEQ_W,
  parameter int ISSUE_W = DEF_ISSUE_W,
  parameter int LAT_W   = DEF_LAT_W,
  parameter int CNT_W   = DEF_CNT_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 can_issue,
  input  logic [NC-1:0]        req_valid,
  input  logic [NC*SEQ_W-1:0]  req_seq,
  input  logic [NC-1:0]        req_squash,
  output logic [NC-1:0]        req_ready,
  input  logic [NC*LAT_W-1:0]  unit_lat,
  input  logic [NC-1:0]        unit_pipe,
  output logic [NC-1:0]        exe_valid,
  output logic [NC*SEQ_W-1:0]  exe_seq,
  output logic [NC-1:0]        cmpl_valid,
  output logic [NC*SEQ_W-1:0]  cmpl_seq,
  output logic [$clog2(NC+1)-1:0] issue_count,
  output logic [NC*CNT_W-1:0]  busy_cnt
);
  localparam int CW = $clog2(NC + 1);

  logic [NC*NC-1:0] older;
  logic [NC-1:0]    unit_free, live, elig, reach, grant, discard, busy_hit;
  logic [LAT_W-1:0] lat_eff  [NC];
  logic [CW-1:0]    n_before [NC];

  iss_age_matrix #(.NC(NC), .SEQ_W(SEQ_W)) u_age (
    .vld   (req_valid),
    .seq   (req_seq),
    .older (older)
  );

  assign live = req_valid & ~req_squash;
  assign elig = live & unit_free;

  // A class is reached when fewer than ISSUE_W older classes are granted
  always_comb begin
    for (int c = 0; c < NC; c++) begin
      if (c == 0 || unit_lat[c*LAT_W +: LAT_W] == '0) lat_eff[c] = LAT_W'(1);
      else                                            lat_eff[c] = unit_lat[c*LAT_W +: LAT_W];
      n_before[c] = '0;
      for (int j = 0; j < NC; j++) begin
        if (older[c*NC+j] && elig[j]) n_before[c] = n_before[c] + CW'(1);
      end
      reach[c] = can_issue && req_valid[c] && (int'(n_before[c]) < ISSUE_W);
    end
  end

  assign grant     = reach & elig;
  assign discard   = reach & req_valid & req_squash;
  assign busy_hit  = reach & live & ~unit_free;
  assign req_ready = grant | discard;

  always_comb begin
    issue_count = '0;
    for (int c = 0; c < NC; c++) begin
      if (grant[c]) issue_count = issue_count + CW'(1);
    end
  end

  for (genvar c = 0; c < NC; c++) begin : g_cls
    iss_unit_track #(.SEQ_W(SEQ_W), .LAT_W(LAT_W), .NO_UNIT(c == 0)) u_trk (
      .clk      (clk),
      .rst_n    (rst_n),
      .grant    (grant[c]),
      .lat_eff  (lat_eff[c]),
      .pipe     (unit_pipe[c]),
      .seq      (req_seq[c*SEQ_W +: SEQ_W]),
      .free     (unit_free[c]),
      .cmpl_v   (cmpl_valid[c]),
      .cmpl_seq (cmpl_seq[c*SEQ_W +: SEQ_W])
    );
    assign exe_valid[c]               = grant[c] && (lat_eff[c] == LAT_W'(1));
    assign exe_seq[c*SEQ_W +: SEQ_W]  = req_seq[c*SEQ_W +: SEQ_W];
  end

  iss_busy_ctr #(.NC(NC), .CNT_W(CNT_W)) u_busy (
    .clk   (clk),
    .rst_n (rst_n),
    .hit   (busy_hit),
    .cnt   (busy_cnt)
  );
endmodule

// File: rtl/iss_oldest_select_chk.sv
module iss_oldest_select_chk #(
  parameter int NC      = 4,
  parameter int SEQ_W   = 16,
  parameter int ISSUE_W = 2,
  parameter int LAT_W   = 3,
  parameter int CNT_W   = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 can_issue,
  input logic [NC-1:0]        req_valid,
  input logic [NC*SEQ_W-1:0]  req_seq,
  input logic [NC-1:0]        req_squash,
  input logic [NC-1:0]        req_ready,
  input logic [NC*LAT_W-1:0]  unit_lat,
  input logic [NC-1:0]        unit_pipe,
  input logic [NC-1:0]        exe_valid,
  input logic [NC*SEQ_W-1:0]  cmpl_seq,
  input logic [NC-1:0]        cmpl_valid,
  input logic [$clog2(NC+1)-1:0] issue_count
);
  // R2
  issue_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(issue_count) <= ISSUE_W);

  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !can_issue |-> (req_ready == '0));

  // R12
  ready_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready & ~req_valid) == '0);

  for (genvar c = 0; c < NC; c++) begin : g_any
    // R5
    squash_no_exe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[c] && req_squash[c]) |-> !exe_valid[c]);
    // R7
    exe_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exe_valid[c] |-> req_ready[c]);
  end

  for (genvar c = 1; c < NC; c++) begin : g_unit
    // R8
    lat_two_cmpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready[c] && !req_squash[c] && unit_lat[c*LAT_W +: LAT_W] == LAT_W'(2))
      |=> (cmpl_valid[c] && cmpl_seq[c*SEQ_W +: SEQ_W] == $past(req_seq[c*SEQ_W +: SEQ_W])));
    // R9
    hold_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready[c] && !req_squash[c] && !unit_pipe[c] &&
       unit_lat[c*LAT_W +: LAT_W] > LAT_W'(1))
      |=> !(req_ready[c] && !req_squash[c]));
  end
endmodule

bind iss_oldest_select iss_oldest_select_chk #(
  .NC(NC), .SEQ_W(SEQ_W), .ISSUE_W(ISSUE_W), .LAT_W(LAT_W), .CNT_W(CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .can_issue   (can_issue),
  .req_valid   (req_valid),
  .req_seq     (req_seq),
  .req_squash  (req_squash),
  .req_ready   (req_ready),
  .unit_lat    (unit_lat),
  .unit_pipe   (unit_pipe),
  .exe_valid   (exe_valid),
  .cmpl_seq    (cmpl_seq),
  .cmpl_valid  (cmpl_valid),
  .issue_count (issue_count)
);

// File: tb/test_iss_oldest_select.sv
`timescale 1ns/1ps
module test_iss_oldest_select;
  localparam int NC = 4, SW = 16, LW = 3, CNW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic can_issue = 1'b0;
  logic [NC-1:0]    req_valid = '0, req_squash = '0, req_ready;
  logic [NC*SW-1:0] req_seq = '0;
  logic [NC*LW-1:0] unit_lat;
  logic [NC-1:0]    unit_pipe;
  logic [NC-1:0]    exe_valid, cmpl_valid;
  logic [NC*SW-1:0] exe_seq, cmpl_seq;
  logic [2:0]       issue_count;
  logic [NC*CNW-1:0] busy_cnt;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  typedef struct {
    int cyc;
    int kind;
    int cls;
    logic [SW-1:0] seq;
    string rq;
  } ev_t;
  ev_t exp_q[$];

  // class 0: table says 5, non-pipelined (must be ignored); class 1: lat 1;
  // class 2: lat 3 non-pipelined; class 3: lat 2 pipelined
  assign unit_lat  = {3'd2, 3'd3, 3'd1, 3'd5};
  assign unit_pipe = 4'b1010;

  iss_oldest_select i_iss_oldest_select (
    .clk(clk), .rst_n(rst_n), .can_issue(can_issue),
    .req_valid(req_valid), .req_seq(req_seq), .req_squash(req_squash),
    .req_ready(req_ready), .unit_lat(unit_lat), .unit_pipe(unit_pipe),
    .exe_valid(exe_valid), .exe_seq(exe_seq), .cmpl_valid(cmpl_valid),
    .cmpl_seq(cmpl_seq), .issue_count(issue_count), .busy_cnt(busy_cnt)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string rq, input string what, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", rq, what, act, expv);
    end
  endtask

  // expected event in the next driven cycle plus delay d
  task automatic expect_ev(input int kind, input int cls, input int seq, input int d, input string rq);
    ev_t e;
    e.cyc = cyc + 1 + d; e.kind = kind; e.cls = cls; e.seq = SW'(seq); e.rq = rq;
    exp_q.push_back(e);
  endtask

  task automatic drive(input logic [3:0] v, input logic [3:0] s,
                       input int a0, input int a1, input int a2, input int a3, input logic ci);
    @(posedge clk); #1;
    req_valid = v; req_squash = s; can_issue = ci;
    req_seq = {SW'(a3), SW'(a2), SW'(a1), SW'(a0)};
    @(negedge clk);
  endtask

  function automatic void match(input int kind, input int cls, input logic [SW-1:0] seq);
    int hit = -1;
    for (int i = 0; i < exp_q.size(); i++)
      if (hit < 0 && exp_q[i].cyc == cyc && exp_q[i].kind == kind &&
          exp_q[i].cls == cls && exp_q[i].seq == seq) hit = i;
    checks++;
    if (hit >= 0) exp_q.delete(hit);
    else begin
      errors++;
      $display("FAIL %s unexpected %s class %0d seq %0d in cycle %0d, expected none",
               kind == 0 ? "R7" : "R8", kind == 0 ? "execute" : "completion", cls, seq, cyc);
    end
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < NC; c++) begin
        if (exe_valid[c])  match(0, c, exe_seq[c*SW +: SW]);
        if (cmpl_valid[c]) match(1, c, cmpl_seq[c*SW +: SW]);
      end
      for (int i = exp_q.size() - 1; i >= 0; i--) begin
        if (exp_q[i].cyc == cyc) begin
          checks++; errors++;
          $display("FAIL %s missing event class %0d actual none expected seq %0d in cycle %0d",
                   exp_q[i].rq, exp_q[i].cls, exp_q[i].seq, cyc);
          exp_q.delete(i);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R12 watchdog actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "req_ready", int'(req_ready), 0);
    chk("R1", "exe_valid", int'(exe_valid), 0);
    chk("R1", "cmpl_valid", int'(cmpl_valid), 0);
    chk("R1", "issue_count", int'(issue_count), 0);
    chk("R1", "busy_cnt", (busy_cnt == '0) ? 1 : 0, 1);

    // R7 R12: single latency-1 candidate
    expect_ev(0, 1, 10, 0, "R7");
    drive(4'b0010, 4'b0000, 0, 10, 0, 0, 1'b1);
    chk("R12", "req_ready", int'(req_ready), 4'b0010);
    chk("R2", "issue_count", int'(issue_count), 1);

    // R4 R2 R8: four candidates, two oldest win
    expect_ev(0, 1, 20, 0, "R4");
    expect_ev(1, 2, 30, 2, "R8");
    drive(4'b1111, 4'b0000, 40, 20, 30, 50, 1'b1);
    chk("R4", "req_ready", int'(req_ready), 4'b0110);
    chk("R2", "issue_count", int'(issue_count), 2);

    // R11 R6: class 2 held, younger classes 3 and 0 issue
    expect_ev(0, 0, 60, 0, "R6");
    expect_ev(1, 3, 50, 1, "R8");
    drive(4'b1101, 4'b0000, 60, 0, 31, 50, 1'b1);
    chk("R11", "req_ready", int'(req_ready), 4'b1001);
    chk("R11", "issue_count", int'(issue_count), 2);

    // R9: completion cycle, unit still held
    drive(4'b0100, 4'b0000, 0, 0, 31, 0, 1'b1);
    chk("R9", "req_ready in completion cycle", int'(req_ready), 0);

    // R9: free the cycle after completion
    expect_ev(1, 2, 31, 2, "R9");
    drive(4'b0100, 4'b0000, 0, 0, 31, 0, 1'b1);
    chk("R9", "req_ready after completion", int'(req_ready), 4'b0100);
    chk("R11", "busy_cnt class 2", int'(busy_cnt[2*CNW +: CNW]), 2);
    chk("R11", "busy_cnt class 3", int'(busy_cnt[3*CNW +: CNW]), 0);
    repeat (3) drive(4'b0000, 4'b0000, 0, 0, 0, 0, 1'b1);

    // R5: squashed oldest costs no slot; class 2 beyond the width untouched
    expect_ev(0, 0, 7, 0, "R5");
    expect_ev(1, 3, 6, 1, "R5");
    drive(4'b1111, 4'b0010, 7, 5, 8, 6, 1'b1);
    chk("R5", "req_ready", int'(req_ready), 4'b1011);
    chk("R5", "issue_count", int'(issue_count), 2);

    // R3: stalled downstream
    drive(4'b1111, 4'b0000, 7, 9, 8, 11, 1'b0);
    chk("R3", "req_ready", int'(req_ready), 0);
    chk("R3", "issue_count", int'(issue_count), 0);
    chk("R5", "busy_cnt class 2 unchanged", int'(busy_cnt[2*CNW +: CNW]), 2);

    // R10: pipelined unit back to back
    for (int k = 0; k < 3; k++) begin
      expect_ev(1, 3, 70 + k, 1, "R10");
      drive(4'b1000, 4'b0000, 0, 0, 0, 70 + k, 1'b1);
      chk("R10", "req_ready", int'(req_ready), 4'b1000);
    end

    // R6: class 0 alone, table latency ignored
    expect_ev(0, 0, 90, 0, "R6");
    drive(4'b0001, 4'b0000, 90, 0, 0, 0, 1'b1);
    chk("R6", "req_ready", int'(req_ready), 4'b0001);

    repeat (5) drive(4'b0000, 4'b0000, 0, 0, 0, 0, 1'b1);
    chk("R8", "pending expected events", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule